// File: doc/BRIEF.md
# Register-access command decoder

This block sits behind a byte-oriented host link and serves request frames against a 64-entry byte register space. The first byte of each frame is an opcode. Its upper bits select the access class. Its lower bits carry either a register index or the high bits of a memory block address. A register write frame carries the data byte second. Every frame ends with one trailing byte that this block accepts but does not verify, because checksum handling belongs to the link layer. The host marks the final byte of a frame with `inLast`. The block answers with a reply frame on the output byte stream.

Most of the register space is plain read/write storage. A few entries have special behaviour:
- Index 0 collects event flags and clears when it is read.
- Indices 4 and 5 expose a 16-bit tick counter. A read of the low byte freezes the high byte for the next read.
- Index 62 is a control register that drives two unlock outputs and carries a reboot command.
- Index 63 always returns an identification value.

Memory-block opcodes are only classified here. They are handed to a request port for a memory agent outside this block.

Top module: `cmd_reg_decoder`

## Requirements
- R1: The opcode byte is classified as follows: bits 7:6 = 00 is a register read, bits 7:6 = 01 is a register write, bits 7:4 = 1000 is a block read and bits 7:4 = 1001 is a block write. For register accesses, bits 5:0 give the index. Every other opcode gets a single reply byte 0x05.
- R2: A frame shorter than 2 bytes, or a register write shorter than 3 bytes, gets a single reply byte 0x01 and has no side effect.
- R3: A register read gets two reply bytes: status 0x00, then the data byte with `outLast`. The first reply byte is valid in the second cycle after the edge that takes the final request byte. The data byte follows in the next cycle.
- R4: A register write frame is opcode, data, trailer. It gets the single reply byte 0x00. A plain register returns the written value on later reads.
- R5: Index 0 holds sticky event flags, one per `evtIn` bit (bit positions 0 to 6). A read returns the flags and clears them.
- R6: An event that arrives in the same cycle as the clearing read of index 0 remains set afterwards.
- R7: The tick counter advances once per cycle with `tickEn` high. A read of index 4 returns the low byte and freezes the high byte. A read of index 5 returns that frozen byte even if the counter has moved on.
- R8: Index 63 always reads 0xB1. Writes to indices 0, 4, 5 and 63 are answered 0x00 but change nothing.
- R9: A write to index 62 stores the byte. Bit 0 drives `unlockEeprom` and bit 1 drives `unlockFlash`. Writing 0xE0 instead pulses `rebootReq` for one cycle and leaves the stored byte unchanged.
- R10: A block opcode with a valid length raises `memReq` for one cycle, in the same cycle as its single 0x00 reply byte. `memWrite` equals opcode bit 4 and `memBlk` equals opcode bits 3:0.
- R11: After reset, no reply is driven, `memReq` and `rebootReq` are low and both unlock outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Request byte valid |
| inByte | input | 8 | Request byte |
| inLast | input | 1 | Final byte of the request frame |
| evtIn | input | 7 | Event pulses, one per flag of index 0 |
| tickEn | input | 1 | Tick counter advance enable |
| outValid | output | 1 | Reply byte valid |
| outByte | output | 8 | Reply byte |
| outLast | output | 1 | Final byte of the reply frame |
| memReq | output | 1 | One-cycle block access request |
| memWrite | output | 1 | Block access direction, 1 = write |
| memBlk | output | 4 | High bits of the block address |
| unlockEeprom | output | 1 | Control bit 0 |
| unlockFlash | output | 1 | Control bit 1 |
| rebootReq | output | 1 | One-cycle reboot request |

## Verification
Let E be the edge that takes the final request byte. Nothing is driven after E itself. The first reply byte appears after edge E+1, together with `memReq`, `rebootReq` and every register side effect, and the read data byte appears after edge E+2. The bench samples on falling edges and counts them from the falling edge that follows E. It requires the first reply byte at count 1 and the pulse outputs at the same count. It drives a coincident event during count 0 so that the event is present at the clearing edge E+1. Side effects are judged only by frames sent after the reply has finished.

// File: rtl/cmd_reg_pkg.sv
package cmd_reg_pkg;
  localparam int BYTE_W    = 8;
  localparam int REG_COUNT = 64;
  localparam int IDX_W     = $clog2(REG_COUNT);
  localparam int EVT_W     = 7;
  localparam int TICK_W    = 2 * BYTE_W;
  localparam int BLK_W     = 4;

  localparam logic [IDX_W-1:0] IDX_CHANGE = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_TICKLO = IDX_W'(4);
  localparam logic [IDX_W-1:0] IDX_TICKHI = IDX_W'(5);
  localparam logic [IDX_W-1:0] IDX_CTRL   = IDX_W'(62);
  localparam logic [IDX_W-1:0] IDX_ID     = IDX_W'(63);

  localparam logic [BYTE_W-1:0] ID_VALUE    = 8'hB1;
  localparam logic [BYTE_W-1:0] REBOOT_CODE = 8'hE0;
  localparam logic [BYTE_W-1:0] ST_OK       = 8'h00;
  localparam logic [BYTE_W-1:0] ST_SHORT    = 8'h01;
  localparam logic [BYTE_W-1:0] ST_ILLEGAL  = 8'h05;

  typedef enum logic [1:0] {CL_READ, CL_WRITE, CL_MEM, CL_BAD} opclass_t;

  typedef struct packed {
    logic              rdStb;
    logic              wrStb;
    logic [IDX_W-1:0]  idx;
    logic [BYTE_W-1:0] wrData;
  } strobe_t;

  function automatic logic isPlainIdx(input int i);
    return !(i == int'(IDX_CHANGE) || i == int'(IDX_TICKLO) || i == int'(IDX_TICKHI) ||
             i == int'(IDX_CTRL) || i == int'(IDX_ID));
  endfunction
endpackage

// File: rtl/cmd_reg_ctrl.sv
module cmd_reg_ctrl
  import cmd_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [BYTE_W-1:0] inByte,
  input  logic              inLast,
  input  logic [BYTE_W-1:0] rdData,
  output strobe_t           stb,
  output logic              outValid,
  output logic [BYTE_W-1:0] outByte,
  output logic              outLast,
  output logic              memReq,
  output logic              memWrite,
  output logic [BLK_W-1:0]  memBlk
);
  logic [BYTE_W-1:0] opReg, dataReg, holdData;
  logic [1:0]        byteCnt, lenReg;
  logic              execPend, sendData;
  opclass_t          opClass;
  logic              tooShort;

  always_comb begin
    if (opReg[7:6] == 2'b00)      opClass = CL_READ;
    else if (opReg[7:6] == 2'b01) opClass = CL_WRITE;
    else if (opReg[7:5] == 3'b100) opClass = CL_MEM;
    else                           opClass = CL_BAD;
    tooShort   = (lenReg < 2'd2) || (opClass == CL_WRITE && lenReg < 2'd3);
    stb.rdStb  = execPend && !tooShort && opClass == CL_READ;
    stb.wrStb  = execPend && !tooShort && opClass == CL_WRITE;
    stb.idx    = opReg[IDX_W-1:0];
    stb.wrData = dataReg;
  end

  // frame collection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opReg    <= '0;
      dataReg  <= '0;
      byteCnt  <= '0;
      lenReg   <= '0;
      execPend <= 1'b0;
    end else begin
      execPend <= 1'b0;
      if (inValid) begin
        if (byteCnt == 2'd0) opReg   <= inByte;
        if (byteCnt == 2'd1) dataReg <= inByte;
        if (inLast) begin
          byteCnt  <= '0;
          lenReg   <= (byteCnt == 2'd3) ? 2'd3 : byteCnt + 2'd1;
          execPend <= 1'b1;
        end else if (byteCnt != 2'd3) begin
          byteCnt <= byteCnt + 2'd1;
        end
      end
    end
  end

  // reply generation
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outByte  <= '0;
      outLast  <= 1'b0;
      holdData <= '0;
      sendData <= 1'b0;
      memReq   <= 1'b0;
      memWrite <= 1'b0;
      memBlk   <= '0;
    end else begin
      outValid <= 1'b0;
      outLast  <= 1'b0;
      outByte  <= '0;
      sendData <= 1'b0;
      memReq   <= 1'b0;
      if (execPend) begin
        outValid <= 1'b1;
        outLast  <= 1'b1;
        if (tooShort) begin
          outByte <= ST_SHORT;
        end else begin
          unique case (opClass)
            CL_READ: begin
              outByte  <= ST_OK;
              outLast  <= 1'b0;
              holdData <= rdData;
              sendData <= 1'b1;
            end
            CL_WRITE: outByte <= ST_OK;
            CL_MEM: begin
              outByte  <= ST_OK;
              memReq   <= 1'b1;
              memWrite <= opReg[4];
              memBlk   <= opReg[BLK_W-1:0];
            end
            default: outByte <= ST_ILLEGAL;
          endcase
        end
      end else if (sendData) begin
        outValid <= 1'b1;
        outLast  <= 1'b1;
        outByte  <= holdData;
      end
    end
  end
endmodule

// File: rtl/cmd_reg_dpath.sv
module cmd_reg_dpath
  import cmd_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [EVT_W-1:0]  evtIn,
  input  logic              tickEn,
  output logic [BYTE_W-1:0] rdData,
  output logic              unlockEeprom,
  output logic              unlockFlash,
  output logic              rebootReq
);
  logic [BYTE_W-1:0] plainQ [REG_COUNT];
  logic [EVT_W-1:0]  changeReg;
  logic [TICK_W-1:0] tickCnt;
  logic [BYTE_W-1:0] tickHiHold;
  logic [BYTE_W-1:0] ctrlReg;

  for (genvar gi = 0; gi < REG_COUNT; gi++) begin : g_reg
    if (isPlainIdx(gi)) begin : g_store
      logic [BYTE_W-1:0] q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= '0;
        else if (stb.wrStb && stb.idx == IDX_W'(gi)) q <= stb.wrData;
      end
      assign plainQ[gi] = q;
    end else begin : g_special
      assign plainQ[gi] = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      changeReg  <= '0;
      tickCnt    <= '0;
      tickHiHold <= '0;
      ctrlReg    <= '0;
      rebootReq  <= 1'b0;
    end else begin
      rebootReq <= 1'b0;
      if (stb.rdStb && stb.idx == IDX_CHANGE) changeReg <= evtIn;
      else                                    changeReg <= changeReg | evtIn;
      if (tickEn) tickCnt <= tickCnt + 1'b1;
      if (stb.rdStb && stb.idx == IDX_TICKLO) tickHiHold <= tickCnt[TICK_W-1 -: BYTE_W];
      if (stb.wrStb && stb.idx == IDX_CTRL) begin
        if (stb.wrData == REBOOT_CODE) rebootReq <= 1'b1;
        else                           ctrlReg   <= stb.wrData;
      end
    end
  end

  always_comb begin
    unique case (stb.idx)
      IDX_CHANGE: rdData = {{(BYTE_W-EVT_W){1'b0}}, changeReg};
      IDX_TICKLO: rdData = tickCnt[BYTE_W-1:0];
      IDX_TICKHI: rdData = tickHiHold;
      IDX_CTRL:   rdData = ctrlReg;
      IDX_ID:     rdData = ID_VALUE;
      default:    rdData = plainQ[stb.idx];
    endcase
  end

  assign unlockEeprom = ctrlReg[0];
  assign unlockFlash  = ctrlReg[1];
endmodule

// File: rtl/cmd_reg_decoder.sv
module cmd_reg_decoder
  import cmd_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [BYTE_W-1:0] inByte,
  input  logic              inLast,
  input  logic [EVT_W-1:0]  evtIn,
  input  logic              tickEn,
  output logic              outValid,
  output logic [BYTE_W-1:0] outByte,
  output logic              outLast,
  output logic              memReq,
  output logic              memWrite,
  output logic [BLK_W-1:0]  memBlk,
  output logic              unlockEeprom,
  output logic              unlockFlash,
  output logic              rebootReq
);
  strobe_t           stb;
  logic [BYTE_W-1:0] rdData;

  cmd_reg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inByte(inByte), .inLast(inLast),
    .rdData(rdData), .stb(stb), .outValid(outValid), .outByte(outByte),
    .outLast(outLast), .memReq(memReq), .memWrite(memWrite), .memBlk(memBlk)
  );

  cmd_reg_dpath u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .evtIn(evtIn), .tickEn(tickEn),
    .rdData(rdData), .unlockEeprom(unlockEeprom), .unlockFlash(unlockFlash),
    .rebootReq(rebootReq)
  );
endmodule

// File: rtl/cmd_reg_decoder_chk.sv
module cmd_reg_decoder_chk (
  input logic clk,
  input logic rstN,
  input logic inValid,
  input logic inLast,
  input logic outValid,
  input logic outLast,
  input logic memReq,
  input logic rebootReq
);
  // R10
  mem_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) memReq |=> !memReq);
  // R10
  mem_reply_chk: assert property (@(posedge clk) disable iff (!rstN) memReq |-> (outValid && outLast));
  // R9
  reboot_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) rebootReq |=> !rebootReq);
  // R3
  last_valid_chk: assert property (@(posedge clk) disable iff (!rstN) outLast |-> outValid);
  // R3
  reply_due_chk: assert property (@(posedge clk) disable iff (!rstN) (inValid && inLast) |=> ##1 outValid);
endmodule

bind cmd_reg_decoder cmd_reg_decoder_chk u_chk (.*);

// File: tb/cmd_reg_decoder_bench.sv
`timescale 1ns/1ps
module cmd_reg_decoder_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [7:0] inByte = '0;
  logic       inLast = 1'b0;
  logic [6:0] evtIn = '0;
  logic       tickEn = 1'b0;
  logic       outValid, outLast, memReq, memWrite, unlockEeprom, unlockFlash, rebootReq;
  logic [7:0] outByte;
  logic [3:0] memBlk;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  cmd_reg_decoder u_cmd_reg_decoder (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inByte(inByte), .inLast(inLast),
    .evtIn(evtIn), .tickEn(tickEn), .outValid(outValid), .outByte(outByte),
    .outLast(outLast), .memReq(memReq), .memWrite(memWrite), .memBlk(memBlk),
    .unlockEeprom(unlockEeprom), .unlockFlash(unlockFlash), .rebootReq(rebootReq)
  );

  typedef struct packed {
    logic [1:0] n;
    logic [7:0] b0, b1, b2;
    logic [1:0] cnt;
    logic [7:0] e0, e1;
    logic [3:0] req;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VECS [NVEC] = '{
    '{2'd2, 8'h3F, 8'h00, 8'h00, 2'd2, 8'h00, 8'hB1, 4'd8},  // R8 id read
    '{2'd3, 8'h50, 8'h5A, 8'h00, 2'd1, 8'h00, 8'h00, 4'd4},  // R4 write 0x10
    '{2'd2, 8'h10, 8'h00, 8'h00, 2'd2, 8'h00, 8'h5A, 4'd4},  // R4 read back
    '{2'd3, 8'h7F, 8'h12, 8'h00, 2'd1, 8'h00, 8'h00, 4'd8},  // R8 write id ignored
    '{2'd2, 8'h3F, 8'h00, 8'h00, 2'd2, 8'h00, 8'hB1, 4'd8},  // R8 id unchanged
    '{2'd2, 8'hA0, 8'h00, 8'h00, 2'd1, 8'h05, 8'h00, 4'd1},  // R1 illegal
    '{2'd2, 8'hC5, 8'h00, 8'h00, 2'd1, 8'h05, 8'h00, 4'd1},  // R1 illegal
    '{2'd1, 8'h10, 8'h00, 8'h00, 2'd1, 8'h01, 8'h00, 4'd2},  // R2 one byte
    '{2'd2, 8'h51, 8'h77, 8'h00, 2'd1, 8'h01, 8'h00, 4'd2},  // R2 short write
    '{2'd2, 8'h11, 8'h00, 8'h00, 2'd2, 8'h00, 8'h00, 4'd2},  // R2 no side effect
    '{2'd2, 8'h85, 8'h00, 8'h00, 2'd1, 8'h00, 8'h00, 4'd10}, // R10 block read
    '{2'd3, 8'h40, 8'hFF, 8'h00, 2'd1, 8'h00, 8'h00, 4'd8},  // R8 write change ignored
    '{2'd2, 8'h00, 8'h00, 8'h00, 2'd2, 8'h00, 8'h00, 4'd5},  // R5 no events yet
    '{2'd3, 8'h7E, 8'h03, 8'h00, 2'd1, 8'h00, 8'h00, 4'd9},  // R9 ctrl write
    '{2'd2, 8'h3E, 8'h00, 8'h00, 2'd2, 8'h00, 8'h03, 4'd9},  // R9 ctrl read
    '{2'd3, 8'h44, 8'h77, 8'h00, 2'd1, 8'h00, 8'h00, 4'd8}   // R8 write tick ignored
  };

  int         repCnt, firstIdx, memCnt, memIdx, rebootCnt, rebootIdx;
  logic [7:0] rep [2];
  logic       lastFlag, memWrS;
  logic [3:0] memBlkS;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic runFrame(input int n, input logic [7:0] b0, input logic [7:0] b1,
                          input logic [7:0] b2, input logic [6:0] evtExec);
    logic [7:0] bytesA [3];
    bytesA = '{b0, b1, b2};
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      inValid = 1'b1; inByte = bytesA[k]; inLast = (k == n - 1);
    end
    @(negedge clk);
    inValid = 1'b0; inLast = 1'b0; inByte = '0; evtIn = evtExec;
    repCnt = 0; firstIdx = -1; lastFlag = 1'b0; rep[0] = '0; rep[1] = '0;
    memCnt = 0; memIdx = -1; memWrS = 1'b0; memBlkS = '0; rebootCnt = 0; rebootIdx = -1;
    for (int k = 0; k < 4; k++) begin
      if (k > 0) @(negedge clk);
      if (k == 1) evtIn = '0;
      if (outValid) begin
        if (repCnt == 0) firstIdx = k;
        if (repCnt < 2) rep[repCnt] = outByte;
        repCnt++;
        lastFlag = outLast;
      end
      if (memReq) begin memCnt++; memIdx = k; memWrS = memWrite; memBlkS = memBlk; end
      if (rebootReq) begin rebootCnt++; rebootIdx = k; end
    end
  endtask

  task automatic readReg(input logic [7:0] idx, input logic [6:0] evtExec);
    runFrame(2, idx, 8'h00, 8'h00, evtExec);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 outValid", outValid, 0);
    chk("R11 memReq", memReq, 0);
    chk("R11 rebootReq", rebootReq, 0);
    chk("R11 unlocks", {unlockFlash, unlockEeprom}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[v].req, v);
      runFrame(int'(VECS[v].n), VECS[v].b0, VECS[v].b1, VECS[v].b2, '0);
      chk({tag, " count"}, repCnt, int'(VECS[v].cnt));
      chk({tag, " byte0"}, rep[0], VECS[v].e0);
      if (VECS[v].cnt == 2'd2) chk({tag, " byte1"}, rep[1], VECS[v].e1);
      chk({tag, " R3 timing"}, firstIdx, 1);
      chk({tag, " R3 last"}, lastFlag, 1);
    end

    // R9 unlock outputs follow control bits written by the table
    chk("R9 unlockEeprom", unlockEeprom, 1);
    chk("R9 unlockFlash", unlockFlash, 1);

    // R10 block read from the table leaves direction low; block write
    runFrame(2, 8'h85, 8'h00, 8'h00, '0);
    chk("R10 read dir", memWrS, 0);
    chk("R10 read blk", memBlkS, 5);
    runFrame(2, 8'h93, 8'h00, 8'h00, '0);
    chk("R10 pulse count", memCnt, 1);
    chk("R10 pulse cycle", memIdx, 1);
    chk("R10 write dir", memWrS, 1);
    chk("R10 write blk", memBlkS, 3);
    chk("R1 block write reply", rep[0], 8'h00);
    runFrame(1, 8'h93, 8'h00, 8'h00, '0);
    chk("R2 short block no request", memCnt, 0);

    // R9 reboot code pulses and keeps stored value
    runFrame(3, 8'h7E, 8'hE0, 8'h00, '0);
    chk("R9 reboot count", rebootCnt, 1);
    chk("R9 reboot cycle", rebootIdx, 1);
    readReg(8'h3E, '0);
    chk("R9 ctrl kept", rep[1], 8'h03);

    // R5 sticky events, R6 event during clearing read
    @(negedge clk); evtIn = 7'h01;
    @(negedge clk); evtIn = 7'h00;
    @(negedge clk); evtIn = 7'h04;
    @(negedge clk); evtIn = 7'h00;
    readReg(8'h00, 7'h20);
    chk("R5 flags read", rep[1], 8'h05);
    readReg(8'h00, '0);
    chk("R6 coincident event kept", rep[1], 8'h20);
    readReg(8'h00, '0);
    chk("R5 cleared", rep[1], 8'h00);

    // R7 tick counter pair
    @(negedge clk); tickEn = 1'b1;
    repeat (300) @(negedge clk);
    tickEn = 1'b0;
    readReg(8'h04, '0);
    chk("R7 low 300", rep[1], 8'h2C);
    @(negedge clk); tickEn = 1'b1;
    repeat (300) @(negedge clk);
    tickEn = 1'b0;
    readReg(8'h05, '0);
    chk("R7 frozen high", rep[1], 8'h01);
    readReg(8'h04, '0);
    chk("R7 low 600", rep[1], 8'h58);
    runFrame(3, 8'h45, 8'h99, 8'h00, '0);
    readReg(8'h05, '0);
    chk("R7 R8 high 600", rep[1], 8'h02);

    summary();
    $finish;
  end
endmodule